// File: doc/BRIEF.md
# Dual Physical Register Free List

This block tracks which physical registers are available to a register renamer. A single physical index space is split at `NUM_PHYS_INT`: the low part holds integer registers and the high part holds floating-point registers. Each class has its own first-in-first-out pool of free indices. Each pool has an allocate port with a request/ready handshake. The granted index appears combinationally in the cycle that the request is accepted.

Freed registers come back in two ways. A typed release port per class pushes the given index unchanged. A unified release port decides the class from the index range. It discards out-of-range indices and both hardwired zero registers. At reset each pool is filled with the indices that remain after the architectural (logical) registers of its class.

Each pool reports an empty flag and a free count. A single sticky error flag records an allocation attempted on an empty pool and a push that finds no room.

Top module: `phys_free_list`

## Requirements
- R1: Each pool returns indices in the order they were pushed (oldest first), independently of the other pool.
- R2: After reset the integer pool holds `NUM_LOG_INT`..`NUM_PHYS_INT-1` in ascending order. The floating-point pool holds `NUM_PHYS_INT+NUM_LOG_FP`..`NUM_PHYS_INT+NUM_PHYS_FP-1` in ascending order. The error flag is low.
- R3: A unified release with index below `NUM_PHYS_INT` enters the integer pool. One from `NUM_PHYS_INT` to `NUM_PHYS_INT+NUM_PHYS_FP-1` enters the floating-point pool. Any larger index changes neither pool.
- R4: A unified release of index `ZERO_IDX` leaves the integer pool unchanged.
- R5: A unified release of index `ZERO_IDX+NUM_PHYS_INT` leaves the floating-point pool unchanged.
- R6: The typed release ports push any index, including zero-register and out-of-range values, and a later allocation returns it.
- R7: `*_count_o` equals the number of entries held, and `*_empty_o` is high exactly when that count is zero.
- R8: A request on an empty pool (with no bypass) is not granted (`*_rdy_o` low). The index output reads 0, and `err_o` goes high on the next edge and stays high until reset.
- R9: An allocation and a release on the same non-empty pool in one cycle are both accepted and the count is unchanged. With `BYPASS=0` an empty pool is not ready even if a release arrives in that cycle.
- R10: With `BYPASS=1`, a request on an empty pool in a cycle with a release is granted the released index, and the count stays 0.
- R11: A pool can hold as many entries as its class has physical registers. A push that finds the pool full is dropped and sets `err_o`.
- R12: A typed and a unified release to the same pool in one cycle are both stored, the typed index ahead of the unified one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_req_i | input | 1 | Integer allocate request |
| int_rdy_o | output | 1 | Integer allocate can be granted |
| int_idx_o | output | IDX_W | Granted integer index, 0 when not granted |
| fp_req_i | input | 1 | Floating-point allocate request |
| fp_rdy_o | output | 1 | Floating-point allocate can be granted |
| fp_idx_o | output | IDX_W | Granted floating-point index, 0 when not granted |
| int_rel_vld_i | input | 1 | Typed integer release valid |
| int_rel_idx_i | input | IDX_W | Typed integer release index |
| fp_rel_vld_i | input | 1 | Typed floating-point release valid |
| fp_rel_idx_i | input | IDX_W | Typed floating-point release index |
| any_rel_vld_i | input | 1 | Unified release valid |
| any_rel_idx_i | input | IDX_W | Unified release index, routed by range |
| int_empty_o | output | 1 | Integer pool empty |
| int_count_o | output | INT_CNT_W | Integer free count |
| fp_empty_o | output | 1 | Floating-point pool empty |
| fp_count_o | output | FP_CNT_W | Floating-point free count |
| err_o | output | 1 | Sticky underflow/overflow error |

## Verification
Unified releases are applied with an index in each range: integer, floating-point, both zero registers and beyond the total. Comparing the two counts afterwards separates correct routing from a misplaced boundary or a missing zero filter. Typed releases of the same zero and out-of-range values show that filtering applies only to the unified port. Full drains of both pools check the FIFO order across reset contents and mixed pushes. Same-cycle allocate/release and dual-release cycles, on a default instance and on a bypass instance, separate count bookkeeping, push ordering and the bypass path from the plain path. Filling a pool to its depth and one step past it separates a correct capacity from an early or missing overflow.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  // pointer advance with wrap, step never exceeds depth
  function automatic int wrap_add(int ptr, int step, int depth);
    int s;
    s = ptr + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/pfl_router.sv
module pfl_router #(
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int ZERO_IDX     = 0,
  parameter int IDX_W        = 6
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             to_int_o,
  output logic             to_fp_o
);
  localparam int TOTAL   = NUM_PHYS_INT + NUM_PHYS_FP;
  localparam int FP_ZERO = ZERO_IDX + NUM_PHYS_INT;

  int idx_v;
  always_comb begin
    idx_v    = int'(idx_i);
    to_int_o = vld_i && (idx_v < NUM_PHYS_INT) && (idx_v != ZERO_IDX);
    to_fp_o  = vld_i && (idx_v >= NUM_PHYS_INT) && (idx_v < TOTAL) && (idx_v != FP_ZERO);
  end
endmodule

// File: rtl/pfl_pool.sv
module pfl_pool #(
  parameter int DEPTH     = 16,
  parameter int INIT_N    = 8,
  parameter int INIT_BASE = 8,
  parameter int IDX_W     = 6,
  parameter bit BYPASS    = 1'b0,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            push_vld_i,   // [0] has priority in order
  input  logic [1:0][IDX_W-1:0] push_idx_i,
  input  logic                  pop_req_i,
  output logic                  pop_rdy_o,
  output logic [IDX_W-1:0]      pop_idx_o,
  output logic                  empty_o,
  output logic [CNT_W-1:0]      count_o,
  output logic                  ovf_o,
  output logic                  udf_o
);
  import pfl_pkg::*;

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  logic [1:0]       pv;
  logic [IDX_W-1:0] pd0, pd1;
  logic             byp, pop_fire, pop_mem;
  logic [IDX_W-1:0] w0, w1;
  int               wn_req, avail, wn;

  // compact pushes so the first valid one sits in slot 0
  always_comb begin
    if (push_vld_i[0]) begin
      pv  = push_vld_i;
      pd0 = push_idx_i[0];
      pd1 = push_idx_i[1];
    end else begin
      pv  = {1'b0, push_vld_i[1]};
      pd0 = push_idx_i[1];
      pd1 = push_idx_i[1];
    end
  end

  always_comb begin
    empty_o   = (cnt_q == '0);
    byp       = BYPASS && empty_o && pop_req_i && pv[0];
    pop_rdy_o = !empty_o || byp;
    pop_fire  = pop_req_i && pop_rdy_o;
    pop_mem   = pop_fire && !byp;
    udf_o     = pop_req_i && !pop_rdy_o;
    if (!pop_fire)  pop_idx_o = '0;
    else if (byp)   pop_idx_o = pd0;
    else            pop_idx_o = mem_q[rd_q];

    if (byp) begin
      w0     = pd1;
      w1     = pd1;
      wn_req = pv[1] ? 1 : 0;
    end else begin
      w0     = pd0;
      w1     = pd1;
      wn_req = (pv[0] ? 1 : 0) + (pv[1] ? 1 : 0);
    end
    avail = DEPTH - int'(cnt_q) + (pop_mem ? 1 : 0);
    wn    = (wn_req > avail) ? avail : wn_req;
    ovf_o = (wn_req > avail);
  end

  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < INIT_N) ? IDX_W'(INIT_BASE + i) : '0;
      rd_q  <= '0;
      wr_q  <= PTR_W'(INIT_N % DEPTH);
      cnt_q <= CNT_W'(INIT_N);
    end else begin
      if (wn >= 1) mem_q[wr_q] <= w0;
      if (wn >= 2) mem_q[PTR_W'(wrap_add(int'(wr_q), 1, DEPTH))] <= w1;
      wr_q <= PTR_W'(wrap_add(int'(wr_q), wn, DEPTH));
      if (pop_mem) rd_q <= PTR_W'(wrap_add(int'(rd_q), 1, DEPTH));
      cnt_q <= CNT_W'(int'(cnt_q) + wn - (pop_mem ? 1 : 0));
    end
  end
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list #(
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_PHYS_FP  = 16,
  parameter int NUM_LOG_FP   = 8,
  parameter int ZERO_IDX     = 0,
  parameter bit BYPASS       = 1'b0,
  localparam int TOTAL       = NUM_PHYS_INT + NUM_PHYS_FP,
  localparam int IDX_W       = $clog2(TOTAL + 1),
  localparam int INT_CNT_W   = $clog2(NUM_PHYS_INT + 1),
  localparam int FP_CNT_W    = $clog2(NUM_PHYS_FP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 int_req_i,
  output logic                 int_rdy_o,
  output logic [IDX_W-1:0]     int_idx_o,
  input  logic                 fp_req_i,
  output logic                 fp_rdy_o,
  output logic [IDX_W-1:0]     fp_idx_o,
  input  logic                 int_rel_vld_i,
  input  logic [IDX_W-1:0]     int_rel_idx_i,
  input  logic                 fp_rel_vld_i,
  input  logic [IDX_W-1:0]     fp_rel_idx_i,
  input  logic                 any_rel_vld_i,
  input  logic [IDX_W-1:0]     any_rel_idx_i,
  output logic                 int_empty_o,
  output logic [INT_CNT_W-1:0] int_count_o,
  output logic                 fp_empty_o,
  output logic [FP_CNT_W-1:0]  fp_count_o,
  output logic                 err_o
);
  logic to_int, to_fp;
  logic int_ovf, int_udf, fp_ovf, fp_udf;
  logic err_q;

  pfl_router #(
    .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
    .ZERO_IDX(ZERO_IDX), .IDX_W(IDX_W)
  ) u_router (
    .vld_i(any_rel_vld_i), .idx_i(any_rel_idx_i),
    .to_int_o(to_int), .to_fp_o(to_fp)
  );

  pfl_pool #(
    .DEPTH(NUM_PHYS_INT), .INIT_N(NUM_PHYS_INT - NUM_LOG_INT),
    .INIT_BASE(NUM_LOG_INT), .IDX_W(IDX_W), .BYPASS(BYPASS)
  ) u_int_pool (
    .clk_i, .rst_ni,
    .push_vld_i({to_int, int_rel_vld_i}),
    .push_idx_i({any_rel_idx_i, int_rel_idx_i}),
    .pop_req_i(int_req_i), .pop_rdy_o(int_rdy_o), .pop_idx_o(int_idx_o),
    .empty_o(int_empty_o), .count_o(int_count_o),
    .ovf_o(int_ovf), .udf_o(int_udf)
  );

  pfl_pool #(
    .DEPTH(NUM_PHYS_FP), .INIT_N(NUM_PHYS_FP - NUM_LOG_FP),
    .INIT_BASE(NUM_PHYS_INT + NUM_LOG_FP), .IDX_W(IDX_W), .BYPASS(BYPASS)
  ) u_fp_pool (
    .clk_i, .rst_ni,
    .push_vld_i({to_fp, fp_rel_vld_i}),
    .push_idx_i({any_rel_idx_i, fp_rel_idx_i}),
    .pop_req_i(fp_req_i), .pop_rdy_o(fp_rdy_o), .pop_idx_o(fp_idx_o),
    .empty_o(fp_empty_o), .count_o(fp_count_o),
    .ovf_o(fp_ovf), .udf_o(fp_udf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | int_ovf | int_udf | fp_ovf | fp_udf;
  end
  assign err_o = err_q;
endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int ZERO_IDX     = 0,
  parameter int IDX_W        = 6,
  parameter int INT_CNT_W    = 5,
  parameter int FP_CNT_W     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 int_req_i,
  input logic                 int_rdy_o,
  input logic                 fp_req_i,
  input logic                 fp_rdy_o,
  input logic                 int_rel_vld_i,
  input logic                 fp_rel_vld_i,
  input logic                 any_rel_vld_i,
  input logic [IDX_W-1:0]     any_rel_idx_i,
  input logic                 int_empty_o,
  input logic [INT_CNT_W-1:0] int_count_o,
  input logic                 fp_empty_o,
  input logic [FP_CNT_W-1:0]  fp_count_o,
  input logic                 err_o
);
  localparam int TOTAL = NUM_PHYS_INT + NUM_PHYS_FP;

  logic int_quiet, fp_quiet;
  assign int_quiet = !int_req_i && !int_rel_vld_i;
  assign fp_quiet  = !fp_req_i && !fp_rel_vld_i;

  AST_INT_POP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_i && int_rdy_o && !int_rel_vld_i && !any_rel_vld_i
    |=> int_count_o == $past(int_count_o) - 1'b1); // R1
  AST_OOR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rel_vld_i && int'(any_rel_idx_i) >= TOTAL && int_quiet && fp_quiet
    |=> $stable(int_count_o) && $stable(fp_count_o)); // R3
  AST_INT_ZERO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rel_vld_i && int'(any_rel_idx_i) == ZERO_IDX && int_quiet
    |=> $stable(int_count_o)); // R4
  AST_FP_ZERO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rel_vld_i && int'(any_rel_idx_i) == ZERO_IDX + NUM_PHYS_INT && fp_quiet
    |=> $stable(fp_count_o)); // R5
  AST_EMPTY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_empty_o && !int_rel_vld_i && !any_rel_vld_i |-> !int_rdy_o); // R7
  AST_FP_EMPTY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_empty_o && !fp_rel_vld_i && !any_rel_vld_i |-> !fp_rdy_o); // R7
  AST_INT_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_i && !int_rdy_o |=> err_o); // R8
  AST_FP_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_req_i && !fp_rdy_o |=> err_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_SWAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_i && int_rdy_o && int_rel_vld_i && !any_rel_vld_i
    |=> $stable(int_count_o)); // R9
  AST_INT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(int_count_o) <= NUM_PHYS_INT); // R11
  AST_FP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fp_count_o) <= NUM_PHYS_FP); // R11
endmodule

bind phys_free_list pfl_checker #(
  .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP), .ZERO_IDX(ZERO_IDX),
  .IDX_W(IDX_W), .INT_CNT_W(INT_CNT_W), .FP_CNT_W(FP_CNT_W)
) u_chk (.*);

// File: tb/phys_free_list_tb.sv
`timescale 1ns/1ps
module phys_free_list_tb;
  localparam int IDX_W = 6;
  localparam int CW    = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic int_req_i = 0, fp_req_i = 0;
  logic int_rel_vld_i = 0, fp_rel_vld_i = 0, any_rel_vld_i = 0;
  logic [IDX_W-1:0] int_rel_idx_i = '0, fp_rel_idx_i = '0, any_rel_idx_i = '0;
  logic int_rdy_o, fp_rdy_o, int_empty_o, fp_empty_o, err_o;
  logic [IDX_W-1:0] int_idx_o, fp_idx_o;
  logic [CW-1:0] int_count_o, fp_count_o;
  logic b_int_rdy, b_fp_rdy, b_int_empty, b_fp_empty, b_err;
  logic [IDX_W-1:0] b_int_idx, b_fp_idx;
  logic [CW-1:0] b_int_count, b_fp_count;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  phys_free_list u_dut (.*);

  phys_free_list #(.BYPASS(1'b1)) u_dut_byp (
    .clk_i, .rst_ni, .int_req_i, .int_rdy_o(b_int_rdy), .int_idx_o(b_int_idx),
    .fp_req_i, .fp_rdy_o(b_fp_rdy), .fp_idx_o(b_fp_idx),
    .int_rel_vld_i, .int_rel_idx_i, .fp_rel_vld_i, .fp_rel_idx_i,
    .any_rel_vld_i, .any_rel_idx_i,
    .int_empty_o(b_int_empty), .int_count_o(b_int_count),
    .fp_empty_o(b_fp_empty), .fp_count_o(b_fp_count), .err_o(b_err)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    int_req_i = 0; fp_req_i = 0;
    int_rel_vld_i = 0; fp_rel_vld_i = 0; any_rel_vld_i = 0;
  endtask

  // {req, op, idx, exp}; op: 0 alloc int, 1 alloc fp, 2 rel int, 3 rel fp,
  // 4 rel unified, 5 int count, 6 fp count, 7 int empty, 8 fp empty
  localparam int NV = 42;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 4'd5, 6'd0,  6'd8},   // R2 int preload count
    {4'd2, 4'd6, 6'd0,  6'd8},   // R2 fp preload count
    {4'd7, 4'd7, 6'd0,  6'd0},   // R7 not empty
    {4'd2, 4'd0, 6'd0,  6'd8},   // R2 first int index
    {4'd1, 4'd0, 6'd0,  6'd9},   // R1
    {4'd2, 4'd1, 6'd0,  6'd24},  // R2 first fp index
    {4'd3, 4'd4, 6'd40, 6'd0},   // R3 out of range
    {4'd3, 4'd5, 6'd0,  6'd6},
    {4'd3, 4'd6, 6'd0,  6'd7},
    {4'd3, 4'd4, 6'd3,  6'd0},   // R3 int range
    {4'd3, 4'd4, 6'd20, 6'd0},   // R3 fp range
    {4'd4, 4'd4, 6'd0,  6'd0},   // R4 int zero
    {4'd5, 4'd4, 6'd16, 6'd0},   // R5 fp zero
    {4'd4, 4'd5, 6'd0,  6'd7},
    {4'd5, 4'd6, 6'd0,  6'd8},
    {4'd6, 4'd2, 6'd0,  6'd0},   // R6 typed zero
    {4'd6, 4'd3, 6'd16, 6'd0},
    {4'd6, 4'd3, 6'd45, 6'd0},   // R6 typed out of range
    {4'd6, 4'd5, 6'd0,  6'd8},
    {4'd6, 4'd6, 6'd0,  6'd10},
    {4'd1, 4'd0, 6'd0,  6'd10},
    {4'd1, 4'd0, 6'd0,  6'd11},
    {4'd1, 4'd0, 6'd0,  6'd12},
    {4'd1, 4'd0, 6'd0,  6'd13},
    {4'd1, 4'd0, 6'd0,  6'd14},
    {4'd1, 4'd0, 6'd0,  6'd15},
    {4'd3, 4'd0, 6'd0,  6'd3},
    {4'd6, 4'd0, 6'd0,  6'd0},
    {4'd7, 4'd5, 6'd0,  6'd0},
    {4'd7, 4'd7, 6'd0,  6'd1},
    {4'd1, 4'd1, 6'd0,  6'd25},
    {4'd1, 4'd1, 6'd0,  6'd26},
    {4'd1, 4'd1, 6'd0,  6'd27},
    {4'd1, 4'd1, 6'd0,  6'd28},
    {4'd1, 4'd1, 6'd0,  6'd29},
    {4'd1, 4'd1, 6'd0,  6'd30},
    {4'd1, 4'd1, 6'd0,  6'd31},
    {4'd3, 4'd1, 6'd0,  6'd20},
    {4'd6, 4'd1, 6'd0,  6'd16},
    {4'd6, 4'd1, 6'd0,  6'd45},
    {4'd7, 4'd6, 6'd0,  6'd0},
    {4'd7, 4'd8, 6'd0,  6'd1}
  };

  task automatic alloc_int(string tag, int exp);
    int_req_i = 1;
    #1;
    check({tag, " rdy"}, int'(int_rdy_o), 1);
    check({tag, " idx"}, int'(int_idx_o), exp);
    @(negedge clk_i);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R2 err after reset", int'(err_o), 0);
    check("R7 fp empty after reset", int'(fp_empty_o), 0);

    for (int k = 0; k < NV; k++) begin
      logic [19:0] v;
      string tag;
      v = VEC[k];
      tag = $sformatf("R%0d vec%0d", v[19:16], k);
      case (v[15:12])
        4'd0: int_req_i = 1;
        4'd1: fp_req_i = 1;
        4'd2: begin int_rel_vld_i = 1; int_rel_idx_i = v[11:6]; end
        4'd3: begin fp_rel_vld_i = 1; fp_rel_idx_i = v[11:6]; end
        4'd4: begin any_rel_vld_i = 1; any_rel_idx_i = v[11:6]; end
        default: ;
      endcase
      #1;
      case (v[15:12])
        4'd0: check(tag, int'(int_idx_o), int'(v[5:0]));
        4'd1: check(tag, int'(fp_idx_o), int'(v[5:0]));
        4'd5: check(tag, int'(int_count_o), int'(v[5:0]));
        4'd6: check(tag, int'(fp_count_o), int'(v[5:0]));
        4'd7: check(tag, int'(int_empty_o), int'(v[5:0]));
        4'd8: check(tag, int'(fp_empty_o), int'(v[5:0]));
        default: ;
      endcase
      @(negedge clk_i);
      idle();
    end
    check("R8 no err before underflow", int'(err_o), 0);

    // R8: request on empty integer pool
    int_req_i = 1;
    #1;
    check("R8 rdy on empty", int'(int_rdy_o), 0);
    check("R8 idx on empty", int'(int_idx_o), 0);
    @(negedge clk_i);
    idle();
    check("R8 err set", int'(err_o), 1);
    repeat (2) @(negedge clk_i);
    check("R8 err sticky", int'(err_o), 1);

    // R9 / R10: alloc and release together on an empty pool
    int_req_i = 1; int_rel_vld_i = 1; int_rel_idx_i = 6'd7;
    #1;
    check("R9 empty pool not ready", int'(int_rdy_o), 0);
    check("R10 bypass ready", int'(b_int_rdy), 1);
    check("R10 bypass idx", int'(b_int_idx), 7);
    @(negedge clk_i);
    idle();
    check("R9 count after release", int'(int_count_o), 1);
    check("R10 bypass count", int'(b_int_count), 0);
    // R9: non-empty swap
    int_req_i = 1; int_rel_vld_i = 1; int_rel_idx_i = 6'd9;
    #1;
    check("R9 swap idx", int'(int_idx_o), 7);
    @(negedge clk_i);
    idle();
    check("R9 swap count", int'(int_count_o), 1);

    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R2 err cleared", int'(err_o), 0);
    check("R2 int count", int'(int_count_o), 8);

    // R12: typed and unified release in one cycle
    int_rel_vld_i = 1; int_rel_idx_i = 6'd5;
    any_rel_vld_i = 1; any_rel_idx_i = 6'd6;
    @(negedge clk_i);
    idle();
    check("R12 count", int'(int_count_o), 10);
    for (int k = 8; k < 16; k++) alloc_int("R12 preload", k);
    alloc_int("R12 typed first", 5);
    alloc_int("R12 unified second", 6);

    // R11: fill to depth, then one more
    for (int k = 0; k < 16; k++) begin
      int_rel_vld_i = 1; int_rel_idx_i = IDX_W'(k);
      @(negedge clk_i);
      idle();
    end
    check("R11 full count", int'(int_count_o), 16);
    check("R11 no err at depth", int'(err_o), 0);
    int_rel_vld_i = 1; int_rel_idx_i = 6'd33;
    @(negedge clk_i);
    idle();
    check("R11 err on overflow", int'(err_o), 1);
    check("R11 count held", int'(int_count_o), 16);
    for (int k = 0; k < 16; k++) alloc_int("R11 drain", k);
    check("R11 dropped entry absent", int'(int_empty_o), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule